// File: doc/BRIEF.md
# Byte-Lane Paged RAM Port

This block is a clocked model of a 16-bit wide static RAM port with active-low controls. Every control, address and write-data input is captured in a register on the system clock. The registered controls are decoded into one of these commands: sleep, deselected, byte standby, write, read or output-off. A write commits to the array on the next edge. A read presents data one edge after it is decoded, and raises a per-lane drive flag that stands in for the tri-state enable of each byte lane.

The two byte lanes are independent. The lower lane is `data[7:0]` and is gated by `lb_n`. The upper lane is `data[15:8]` and is gated by `ub_n`. Reads are faster inside an open page. A page is the set of words that share address bits `[ADDR_W-1:PAGE_W]`. A read that hits the open page is served right away. A read outside it must be held for `RAND_CYC` decode cycles before data appears, and that read then opens its page. The array holds `2**DEPTH_W` words. Higher address bits alias onto it, but they still take part in the page comparison.

Top module: `paged_sram_port`

## Requirements
- R1: After reset, and until the first read completes, `drv_lo` and `drv_hi` are 0 and `rdata` is 0.
- R2: The decode priority is: `slp_n` low, then `cs_n` high, then `ub_n` and `lb_n` both high, then `we_n` low, then `oe_n` low. If none of these applies, the command is output-off. Outputs always reflect the command from inputs sampled two rising edges earlier.
- R3: Each byte lane obeys its own enable for both reads and writes. `lb_n` low selects bits 7:0 and `ub_n` low selects bits 15:8. A lane whose enable is high is neither written nor driven.
- R4: With `cs_n` low, `slp_n` high and `we_n` low, each enabled lane of `wdata` is stored at the address, whatever `oe_n` is. Both drive flags are 0 for the result of that cycle.
- R5: With `cs_n` low and both `we_n` and `oe_n` high, the lanes are undriven and the array is unchanged.
- R6: With both byte enables high, the result is standby. Nothing is written, nothing is driven, and the open page is closed.
- R7: With `cs_n` high, the result is standby with both lanes undriven and the open page closed.
- R8: With `slp_n` low, no write or read takes place, whatever the other inputs are, and the open page is closed.
- R9: A read outside the open page, or with no page open, drives data only on its `RAND_CYC`-th consecutive read-decode cycle at the same address. If the address changes, the count restarts. That read then opens its page.
- R10: A read whose bits `[ADDR_W-1:PAGE_W]` match the open page drives data on the edge right after its decode.
- R11: Writes and output-off cycles leave the open page open.
- R12: Only address bits `[DEPTH_W-1:0]` select a word, so addresses that differ only above them reach the same word.
- R13: A lane that is not driven shows 0 on its bits of `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| slp_n | input | 1 | Power pin; low puts the port to sleep |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| drv_lo | output | 1 | Lower lane driven |
| drv_hi | output | 1 | Upper lane driven |

## Verification
The assertions check on every cycle that no lane is driven two edges after a write, sleep, deselect, output-off or byte-standby input. They also check that a driven lane was enabled and read-decoded two edges earlier, and that an undriven lane reads as zero. Only the bench scenarios can show stored contents. These include the partial-lane writes, the aliased addresses and the writes ignored during sleep. The bench scenarios also cover the miss count, which restarts on an address change, and which events keep or close the open page.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  typedef enum logic [2:0] {
    CMD_SLEEP = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_BSTBY = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_READ  = 3'd4,
    CMD_OFF   = 3'd5
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
    logic slp_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                ub_n: 1'b1, lb_n: 1'b1, slp_n: 1'b1};
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctl_t              ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q   <= ctl_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_port_pkg::*;
#(
  parameter int LANES = 2
) (
  input  ctl_t             ctl,
  output cmd_e             cmd,
  output logic [LANES-1:0] lane_en
);
  always_comb begin
    lane_en    = '0;
    lane_en[0] = ~ctl.lb_n;
    lane_en[LANES-1] = ~ctl.ub_n;
    if (!ctl.slp_n)                cmd = CMD_SLEEP;
    else if (ctl.cs_n)             cmd = CMD_DESEL;
    else if (ctl.ub_n && ctl.lb_n) cmd = CMD_BSTBY;
    else if (!ctl.we_n)            cmd = CMD_WRITE;
    else if (!ctl.oe_n)            cmd = CMD_READ;
    else                           cmd = CMD_OFF;
  end
endmodule

// File: rtl/sram_page_ctl.sv
module sram_page_ctl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PAGE_W   = 4,
  parameter int RAND_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_go
);
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = (RAND_CYC > 2) ? $clog2(RAND_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RAND_CYC - 1);

  logic             pg_vld;
  logic [PG_W-1:0]  pg_q;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] miss_addr;
  logic [PG_W-1:0]  addr_pg;
  logic is_rd, hit, miss, go_miss, close;

  always_comb begin
    addr_pg = addr[ADDR_W-1:PAGE_W];
    is_rd   = (cmd == CMD_READ);
    close   = (cmd == CMD_SLEEP) || (cmd == CMD_DESEL) || (cmd == CMD_BSTBY);
    hit     = is_rd && pg_vld && (pg_q == addr_pg);
    miss    = is_rd && !hit;
    go_miss = miss && (cnt == LAST) && (addr == miss_addr);
    rd_go   = hit || go_miss;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_vld    <= 1'b0;
      pg_q      <= '0;
      cnt       <= '0;
      miss_addr <= '0;
    end else begin
      if (close) pg_vld <= 1'b0;
      else if (go_miss) begin
        pg_vld <= 1'b1;
        pg_q   <= addr_pg;
      end
      if (!miss || go_miss) cnt <= '0;
      else if (cnt == '0 || addr != miss_addr) begin
        cnt       <= CNT_W'(1);
        miss_addr <= addr;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH_W = 10,
  parameter int LANE_W  = 8,
  parameter int LANES   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_en,
  input  logic [DEPTH_W-1:0]      idx,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        drv
);
  localparam int DEPTH = 1 << DEPTH_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[g*LANE_W +: LANE_W] <= '0;
        drv[g]                    <= 1'b0;
      end else if (rd_en && lane_en[g]) begin
        rdata[g*LANE_W +: LANE_W] <= mem[idx];
        drv[g]                    <= 1'b1;
      end else begin
        rdata[g*LANE_W +: LANE_W] <= '0;
        drv[g]                    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/paged_sram_port.sv
module paged_sram_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DEPTH_W  = 10,
  parameter int PAGE_W   = 4,
  parameter int RAND_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              slp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              drv_lo,
  output logic              drv_hi
);
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  ctl_t              ctl_in, ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  cmd_e              cmd;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  drv;
  logic              rd_go;

  always_comb begin
    ctl_in = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n,
               ub_n: ub_n, lb_n: lb_n, slp_n: slp_n};
  end

  sram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .ctl_i(ctl_in), .addr_i(addr), .wdata_i(wdata),
    .ctl_q(ctl_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .ctl(ctl_q), .cmd(cmd), .lane_en(lane_en)
  );

  sram_page_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RAND_CYC(RAND_CYC)) u_page (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr_q), .rd_go(rd_go)
  );

  sram_lane_array #(.DEPTH_W(DEPTH_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst(rst),
    .wr_en(cmd == CMD_WRITE), .rd_en(rd_go), .lane_en(lane_en),
    .idx(addr_q[DEPTH_W-1:0]), .wdata(wdata_q),
    .rdata(rdata), .drv(drv)
  );

  assign drv_lo = drv[0];
  assign drv_hi = drv[1];
endmodule

// File: rtl/paged_sram_port_chk.sv
module paged_sram_port_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              ub_n,
  input logic              lb_n,
  input logic              slp_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       rdata,
  input logic              drv_lo,
  input logic              drv_hi
);
  assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> ##2 (!drv_lo && !drv_hi));

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !slp_n |-> ##2 (!drv_lo && !drv_hi));

  assert_bytes_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (ub_n && lb_n) |-> ##2 (!drv_lo && !drv_hi));

  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n) |-> ##2 (!drv_lo && !drv_hi));

  assert_out_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && we_n && oe_n) |-> ##2 (!drv_lo && !drv_hi));

  assert_lo_lane_cause_R3: assert property (@(posedge clk) disable iff (rst)
    drv_lo |-> ($past(!lb_n, 2) && $past(!cs_n, 2) && $past(we_n, 2)
                && $past(!oe_n, 2) && $past(slp_n, 2)));

  assert_hi_lane_cause_R3: assert property (@(posedge clk) disable iff (rst)
    drv_hi |-> ($past(!ub_n, 2) && $past(!cs_n, 2) && $past(we_n, 2)
                && $past(!oe_n, 2) && $past(slp_n, 2)));

  assert_idle_lo_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !drv_lo |-> (rdata[7:0] == 8'h00));

  assert_idle_hi_zero_R13: assert property (@(posedge clk) disable iff (rst)
    !drv_hi |-> (rdata[15:8] == 8'h00));
endmodule

bind paged_sram_port paged_sram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .ub_n(ub_n), .lb_n(lb_n), .slp_n(slp_n), .addr(addr),
  .rdata(rdata), .drv_lo(drv_lo), .drv_hi(drv_hi)
);

// File: tb/paged_sram_port_tb.sv
module paged_sram_port_tb;
  localparam int AW = 20;
  localparam int DW = 10;
  localparam int DEPTH = 1 << DW;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, slp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic drv_lo, drv_hi;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  paged_sram_port #(.ADDR_W(AW), .DEPTH_W(DW), .PAGE_W(4), .RAND_CYC(RC)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .slp_n(slp_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drv_lo(drv_lo), .drv_hi(drv_hi)
  );

  // reference model state
  logic [15:0] mm [DEPTH];
  logic m_cs = 1, m_oe = 1, m_we = 1, m_ub = 1, m_lb = 1, m_slp = 1;
  logic [AW-1:0] m_a = '0;
  logic [15:0] m_d = '0;
  string m_tag = "R1";
  string chk_tag = "R1";
  bit page_open = 0;
  int page = 0;
  int miss_run = 0;
  logic [AW-1:0] miss_a = '0;
  logic [15:0] e_d = '0;
  bit e_lo = 0, e_hi = 0;

  task automatic model_edge();
    bit sel, go, hit;
    e_d = '0; e_lo = 0; e_hi = 0; go = 0;
    sel = !m_cs && m_slp && !(m_ub && m_lb);
    if (!sel) begin
      page_open = 0; miss_run = 0;
    end else if (!m_we) begin
      if (!m_lb) mm[m_a % DEPTH][7:0]  = m_d[7:0];
      if (!m_ub) mm[m_a % DEPTH][15:8] = m_d[15:8];
      miss_run = 0;
    end else if (!m_oe) begin
      hit = page_open && (int'(m_a >> 4) == page);
      if (hit) begin
        go = 1; miss_run = 0;
      end else begin
        if (miss_run > 0 && m_a == miss_a) miss_run++;
        else begin miss_run = 1; miss_a = m_a; end
        if (miss_run == RC) begin
          go = 1; miss_run = 0; page_open = 1; page = int'(m_a >> 4);
        end
      end
      if (go) begin
        e_lo = !m_lb; e_hi = !m_ub;
        if (e_lo) e_d[7:0]  = mm[m_a % DEPTH][7:0];
        if (e_hi) e_d[15:8] = mm[m_a % DEPTH][15:8];
      end
    end else miss_run = 0;
    chk_tag = m_tag;
    m_cs = cs_n; m_oe = oe_n; m_we = we_n; m_ub = ub_n; m_lb = lb_n; m_slp = slp_n;
    m_a = addr; m_d = wdata; m_tag = "";
  endtask

  task automatic compare(input string tag);
    total++;
    if (rdata !== e_d || drv_lo !== e_lo || drv_hi !== e_hi) begin
      bad++;
      $display("FAIL %s actual=%h/%b%b expected=%h/%b%b", tag, rdata, drv_hi, drv_lo,
               e_d, e_hi, e_lo);
    end
  endtask

  string pend_tag = "R1";

  // drive one cycle of inputs, clock it, check outputs
  task automatic cyc(input string tag, input logic c, input logic o, input logic w,
                     input logic u, input logic l, input logic s,
                     input logic [AW-1:0] a, input logic [15:0] d);
    cs_n = c; oe_n = o; we_n = w; ub_n = u; lb_n = l; slp_n = s; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    m_tag = tag;
    @(negedge clk);
    compare(chk_tag);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic u, input logic l);
    cyc(tag, 0, 0, 1, u, l, 1, a, 16'h0);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [15:0] d,
                    input logic u, input logic l);
    cyc(tag, 0, 1, 0, u, l, 1, a, d);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1, 1, 1, 1, 1, 1, '0, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    total++;
    if (rdata !== 16'h0 || drv_lo !== 1'b0 || drv_hi !== 1'b0) begin
      bad++;
      $display("FAIL R1 actual=%h/%b%b expected=0000/00", rdata, drv_hi, drv_lo);
    end
    rst = 1'b0;
    idle("R1"); idle("R1");
    // preload every word with a word write (R4)
    for (int i = 0; i < DEPTH; i++)
      wr("R4", AW'(i), 16'(i * 16'h0101 ^ 16'h5a3c), 0, 0);
    idle("R7");
    // random read: held RC cycles (R9), extra hold is a page hit (R10)
    for (int k = 0; k < RC + 1; k++) rd("R9", AW'(5), 0, 0);
    rd("R10", AW'(6), 0, 0);
    rd("R3", AW'(7), 1, 0);
    rd("R3", AW'(7), 0, 1);
    // byte write with oe low: write wins (R4, R3)
    cyc("R4", 0, 0, 0, 1, 0, 1, AW'(8), 16'hbeef);
    cyc("R3", 0, 1, 0, 0, 1, 1, AW'(9), 16'hc0de);
    rd("R11", AW'(8), 0, 0);
    rd("R3", AW'(9), 0, 0);
    // output-off keeps the page (R5, R11)
    cyc("R5", 0, 1, 1, 0, 0, 1, AW'(10), 16'h0);
    rd("R11", AW'(10), 0, 0);
    // byte standby closes page and blocks write (R6)
    cyc("R6", 0, 1, 0, 1, 1, 1, AW'(11), 16'hdead);
    for (int k = 0; k < RC; k++) rd("R6", AW'(11), 0, 0);
    // chip deselect closes page (R7)
    cyc("R7", 1, 0, 0, 0, 0, 1, AW'(12), 16'h1111);
    for (int k = 0; k < RC; k++) rd("R7", AW'(12), 0, 0);
    // sleep blocks write and closes page (R8)
    cyc("R8", 0, 1, 0, 0, 0, 0, AW'(13), 16'h2222);
    cyc("R8", 0, 0, 1, 0, 0, 0, AW'(13), 16'h0);
    for (int k = 0; k < RC; k++) rd("R8", AW'(13), 0, 0);
    // aliasing: upper address bits reach the same word (R12)
    wr("R12", AW'(DEPTH + 14), 16'h7e57, 0, 0);
    for (int k = 0; k < RC; k++) rd("R12", AW'(14), 0, 0);
    for (int k = 0; k < RC; k++) rd("R12", AW'(3 * DEPTH + 14), 0, 0);
    // address change mid-miss restarts the count (R9)
    rd("R9", AW'(40), 0, 0); rd("R9", AW'(40), 0, 0);
    for (int k = 0; k < RC; k++) rd("R9", AW'(41), 0, 0);
    rd("R10", AW'(47), 0, 0);
    rd("R9", AW'(48), 0, 0);
    // decode priority sweep (R2)
    cyc("R2", 0, 0, 0, 0, 0, 0, AW'(50), 16'h3333);
    cyc("R2", 1, 0, 1, 0, 0, 1, AW'(50), 16'h0);
    for (int k = 0; k < RC; k++) rd("R2", AW'(50), 0, 0);
    idle("R13"); idle("R13"); idle("R13");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule